// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block steps a microcoded controller through its control store. A pipeline register holds the microinstruction now executing, and its control bits drive the data path. The sequencer and condition fields of that same word choose, combinationally, the address of the next microinstruction. The ROM reads that address while the current word executes, so each clock both fetches one word and executes another.

The next address comes from one of five sources: the microprogram counter, the top of a four-entry return stack, the branch field, a mapped opcode start address, or an interrupt service address. A condition field tests one of four status flags, or a constant, with a selectable polarity. A status register loads the data path's carry, zero, negative and overflow flags on every clock. When the test fails, the requested transfer is replaced by a plain continue.

The ROM is read asynchronously outside the block, and its word comes back on `rom_data` in the same cycle. Reset is asynchronous and active low. It clears the counter, the stack, the status register and the pipeline register, so fetching starts at address zero.

Top module: `micro_seq`

## Requirements
- R1: While `rst_n` is low, `uaddr` and `ctrl` are zero and `stk_err` is low. After release, the first word fetched is the one at address 0.
- R2: The counter loads `uaddr`+1 (modulo 2^AW) on every clock. Op code 0 (continue) presents the counter on `uaddr`.
- R3: Op code 1 (jump) with a true condition presents the branch field, word bits [AW+7:8], on `uaddr`.
- R4: Condition field bits [7:4]. Bit 6 set selects the status flag indexed by bits [5:4] (0 carry, 1 zero, 2 negative, 3 overflow); bit 6 clear selects constant true. Bit 7 inverts the result.
- R5: For op codes 1 to 5, a false condition presents the counter on `uaddr` and leaves the stack unchanged.
- R6: Op code 2 (call) with a true condition jumps to the branch field and pushes the counter value. Op code 3 (return) with a true condition presents the stack top and pops it.
- R7: With a true condition, op code 4 presents `map_addr` and op code 5 presents `irq_addr`.
- R8: The stack holds 4 entries. A push onto a full stack overwrites the top entry and leaves the depth at 4.
- R9: A pop from an empty stack presents the bottom entry and raises `stk_err` in that cycle.
- R10: `ctrl` equals bits [UW-1:AW+8] of the `rom_data` word captured at the previous clock edge.
- R11: Conditions test the status register, which loads `alu_flags` on every clock edge.
- R12: Op codes 6 to 15 behave as continue.
- R13: `uaddr` follows a change of `map_addr` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_data | input | CW+AW+8 | Microinstruction read at `uaddr`: {ctrl, branch, cond, op} |
| alu_flags | input | 4 | Data-path flags {overflow, negative, zero, carry} |
| map_addr | input | AW | Start address mapped from the machine opcode |
| irq_addr | input | AW | Interrupt service routine address |
| uaddr | output | AW | Next microaddress to the ROM (combinational) |
| ctrl | output | CW | Registered data-path control bits |
| stk_err | output | 1 | Pop of an empty stack in this cycle |

## Verification
The bench uses AW=8, CW=8 and DEPTH=4, so the whole 256-word control store fits in a behavioural array. A short program can nest five calls deep, which overruns the stack and then drains it below empty. A flag pattern that changes every cycle drives both outcomes of each flag test and both polarities. Changing `map_addr` in the middle of a cycle exposes the combinational path from the pipeline register to `uaddr`.

// File: rtl/micro_seq_pkg.sv
package micro_seq_pkg;
  localparam int OP_W = 4;
  localparam int CC_W = 4;
  localparam int FLAG_W = 4;

  localparam logic [OP_W-1:0] OP_CONT = 4'd0;
  localparam logic [OP_W-1:0] OP_JUMP = 4'd1;
  localparam logic [OP_W-1:0] OP_CALL = 4'd2;
  localparam logic [OP_W-1:0] OP_RET  = 4'd3;
  localparam logic [OP_W-1:0] OP_MAP  = 4'd4;
  localparam logic [OP_W-1:0] OP_VEC  = 4'd5;

  typedef enum logic [2:0] {SRC_PC, SRC_BA, SRC_STK, SRC_MAP, SRC_VEC} src_e;
  typedef enum logic [1:0] {STK_HOLD, STK_PUSH, STK_POP} stk_e;
endpackage

// File: rtl/micro_seq_cond.sv
module micro_seq_cond
  import micro_seq_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [CC_W-1:0]   cc,
  input  logic [FLAG_W-1:0] flags,
  output logic              cond_ok,
  output src_e              src,
  output stk_e              stk_act
);
  logic flag_sel;
  logic raw_test;

  always_comb begin
    flag_sel = flags[cc[1:0]];
    raw_test = cc[2] ? flag_sel : 1'b1;
    cond_ok  = raw_test ^ cc[3];
    src      = SRC_PC;
    stk_act  = STK_HOLD;
    if (cond_ok) begin
      case (op)
        OP_JUMP: src = SRC_BA;
        OP_CALL: begin src = SRC_BA;  stk_act = STK_PUSH; end
        OP_RET:  begin src = SRC_STK; stk_act = STK_POP;  end
        OP_MAP:  src = SRC_MAP;
        OP_VEC:  src = SRC_VEC;
        default: src = SRC_PC;
      endcase
    end
  end
endmodule

// File: rtl/micro_seq_stack.sv
module micro_seq_stack
  import micro_seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_e          act,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top,
  output logic [SPW-1:0] sp,
  output logic          err
);
  localparam logic [SPW-1:0] FULL = SPW'(DEPTH);

  logic [SPW-1:0] sp_q, sp_d, rd_idx;
  logic [AW-1:0]  mem_q [DEPTH];
  logic [DEPTH-1:0] wr_en;

  // pointer next state
  always_comb begin
    sp_d = sp_q;
    if (act == STK_PUSH && sp_q != FULL) sp_d = sp_q + SPW'(1);
    if (act == STK_POP && sp_q != '0)    sp_d = sp_q - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  // one register per entry with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_comb begin
      if (sp_q == FULL) wr_en[g] = (act == STK_PUSH) && (g == DEPTH - 1);
      else              wr_en[g] = (act == STK_PUSH) && (sp_q == SPW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem_q[g] <= '0;
      else if (wr_en[g]) mem_q[g] <= push_val;
    end
  end

  // read: top entry, or the bottom entry once the stack is empty
  always_comb begin
    rd_idx = (sp_q == '0) ? '0 : sp_q - SPW'(1);
    top    = mem_q[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == SPW'(i)) top = mem_q[i];
    end
    err = (act == STK_POP) && (sp_q == '0);
    sp  = sp_q;
  end
endmodule

// File: rtl/micro_seq_nextaddr.sv
module micro_seq_nextaddr
  import micro_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  src_e          src,
  input  logic [AW-1:0] upc,
  input  logic [AW-1:0] branch,
  input  logic [AW-1:0] stk_top,
  input  logic [AW-1:0] map_addr,
  input  logic [AW-1:0] irq_addr,
  output logic [AW-1:0] nxt
);
  always_comb begin
    case (src)
      SRC_BA:  nxt = branch;
      SRC_STK: nxt = stk_top;
      SRC_MAP: nxt = map_addr;
      SRC_VEC: nxt = irq_addr;
      default: nxt = upc;
    endcase
  end
endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import micro_seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW+AW+7:0]      rom_data,
  input  logic [FLAG_W-1:0]     alu_flags,
  input  logic [AW-1:0]         map_addr,
  input  logic [AW-1:0]         irq_addr,
  output logic [AW-1:0]         uaddr,
  output logic [CW-1:0]         ctrl,
  output logic                  stk_err
);
  localparam int UW  = CW + AW + OP_W + CC_W;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int BA_LO = OP_W + CC_W;

  logic [UW-1:0]     pipe_q, pipe_d;
  logic [FLAG_W-1:0] status_q, status_d;
  logic [AW-1:0]     upc_q, upc_d;
  logic              pipe_en;

  logic [OP_W-1:0]   op;
  logic [CC_W-1:0]   cc;
  logic [AW-1:0]     ba;
  logic              cond_ok;
  src_e              src;
  stk_e              stk_act;
  logic [AW-1:0]     stk_top;
  logic [SPW-1:0]    sp_q;

  // fields of the executing word
  assign op   = pipe_q[OP_W-1:0];
  assign cc   = pipe_q[OP_W+CC_W-1:OP_W];
  assign ba   = pipe_q[BA_LO+AW-1:BA_LO];
  assign ctrl = pipe_q[UW-1:BA_LO+AW];

  // next state: every register advances on every clock
  always_comb begin
    pipe_en  = 1'b1;
    pipe_d   = rom_data;
    status_d = alu_flags;
    upc_d    = uaddr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      status_q <= '0;
      upc_q    <= '0;
    end else if (pipe_en) begin
      pipe_q   <= pipe_d;
      status_q <= status_d;
      upc_q    <= upc_d;
    end
  end

  micro_seq_cond u_cond (
    .op      (op),
    .cc      (cc),
    .flags   (status_q),
    .cond_ok (cond_ok),
    .src     (src),
    .stk_act (stk_act)
  );

  micro_seq_stack #(.AW(AW), .DEPTH(DEPTH), .SPW(SPW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (stk_act),
    .push_val (upc_q),
    .top      (stk_top),
    .sp       (sp_q),
    .err      (stk_err)
  );

  micro_seq_nextaddr #(.AW(AW)) u_next (
    .src      (src),
    .upc      (upc_q),
    .branch   (ba),
    .stk_top  (stk_top),
    .map_addr (map_addr),
    .irq_addr (irq_addr),
    .nxt      (uaddr)
  );
endmodule

// File: rtl/micro_seq_chk.sv
module micro_seq_chk
  import micro_seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  parameter int SPW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   uaddr,
  input logic [CW-1:0]   ctrl,
  input logic [CW-1:0]   rom_ctrl,
  input logic [AW-1:0]   map_addr,
  input logic [AW-1:0]   irq_addr,
  input logic [AW-1:0]   ba,
  input logic [AW-1:0]   upc_q,
  input logic [SPW-1:0]  sp_q,
  input logic [OP_W-1:0] op,
  input logic            cond_ok,
  input stk_e            stk_act,
  input logic            stk_err,
  input logic [AW-1:0]   stk_top
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (uaddr == '0 && ctrl == '0 && !stk_err));

  assert_upc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> upc_q == $past(uaddr) + AW'(1));

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP && cond_ok) |-> uaddr == ba);

  assert_fail_cont_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |-> (uaddr == upc_q && stk_act == STK_HOLD));

  assert_fail_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> $stable(sp_q));

  assert_ret_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET && cond_ok) |-> uaddr == stk_top);

  assert_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MAP && cond_ok) |-> uaddr == map_addr);

  assert_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_VEC && cond_ok) |-> uaddr == irq_addr);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH));

  assert_full_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_act == STK_PUSH && sp_q == SPW'(DEPTH)) |=> sp_q == SPW'(DEPTH));

  assert_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |-> (sp_q == '0 && stk_act == STK_POP));

  assert_ctrl_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ctrl == $past(rom_ctrl));

  assert_undef_cont_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OP_VEC) |-> uaddr == upc_q);
endmodule

bind micro_seq micro_seq_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .uaddr    (uaddr),
  .ctrl     (ctrl),
  .rom_ctrl (rom_data[UW-1:BA_LO+AW]),
  .map_addr (map_addr),
  .irq_addr (irq_addr),
  .ba       (ba),
  .upc_q    (upc_q),
  .sp_q     (sp_q),
  .op       (op),
  .cond_ok  (cond_ok),
  .stk_act  (stk_act),
  .stk_err  (stk_err),
  .stk_top  (stk_top)
);

// File: tb/tb_micro_seq.sv
module tb_micro_seq;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DEPTH = 4;
  localparam int UW = CW + AW + 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [UW-1:0] rom_data;
  logic [3:0]    alu_flags;
  logic [AW-1:0] map_addr, irq_addr, uaddr;
  logic [CW-1:0] ctrl;
  logic          stk_err;

  logic [UW-1:0] rom [256];

  always #4 clk = ~clk;
  assign rom_data = rom[uaddr];

  micro_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rom_data(rom_data), .alu_flags(alu_flags),
    .map_addr(map_addr), .irq_addr(irq_addr), .uaddr(uaddr), .ctrl(ctrl),
    .stk_err(stk_err)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  logic [UW-1:0] m_pipe;
  int m_upc, m_bottom, m_status;
  int m_stk[$];
  bit m_ovf;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [UW-1:0] w(int op, int cc, int ba, int c);
    return {CW'(c), AW'(ba), 4'(cc), 4'(op)};
  endfunction

  task automatic model_reset();
    m_pipe = '0; m_upc = 0; m_bottom = 0; m_status = 0; m_ovf = 0;
    m_stk.delete();
  endtask

  // expected next address, stack action (0 hold, 1 push, 2 pop), error, tag
  task automatic model_next(output int addr, output int act, output bit err, output string tag);
    int op, cc, ba;
    bit truth;
    op = int'(m_pipe[3:0]); cc = int'(m_pipe[7:4]); ba = int'(m_pipe[15:8]);
    truth = (cc & 4) ? bit'((m_status >> (cc & 3)) & 1) : 1'b1;
    if (cc & 8) truth = !truth;
    addr = m_upc; act = 0; err = 0; tag = "R2";
    if (op >= 6) tag = "R12";
    else if (op >= 1 && !truth) tag = (cc & 4) ? "R5" : "R4";
    else if (op >= 1) begin
      tag = (cc & 4) ? "R11" : "R3";
      case (op)
        2: begin addr = ba; act = 1; if (!(cc & 4)) tag = "R6"; end
        3: begin
          act = 2;
          if (m_stk.size() == 0) begin addr = m_bottom; err = 1; tag = "R9"; end
          else begin addr = m_stk[$]; if (m_ovf) tag = "R8"; else if (!(cc & 4)) tag = "R6"; end
        end
        4: begin addr = int'(map_addr); tag = "R7"; end
        5: begin addr = int'(irq_addr); tag = "R7"; end
        default: addr = ba;
      endcase
    end
  endtask

  task automatic model_clock(input int addr, input int act);
    if (act == 1) begin
      if (m_stk.size() == 0) m_bottom = m_upc;
      if (m_stk.size() < DEPTH) m_stk.push_back(m_upc);
      else begin m_stk[DEPTH-1] = m_upc; m_ovf = 1; end
    end else if (act == 2 && m_stk.size() > 0) begin
      void'(m_stk.pop_back());
      if (m_stk.size() == 0) m_ovf = 0;
    end
    m_pipe = rom[addr];
    m_upc = (addr + 1) % 256;
    m_status = int'(alu_flags);
  endtask

  task automatic run(input int n);
    int e_addr, e_act;
    bit e_err;
    string tag;
    for (int i = 0; i < n; i++) begin
      alu_flags = 4'((i * 5) ^ (i >> 3));
      map_addr  = ((i >> 3) & 1) ? 8'd140 : 8'd120;
      irq_addr  = 8'd160;
      #1;
      model_next(e_addr, e_act, e_err, tag);
      chk(tag, 32'(uaddr), 32'(e_addr));
      chk("R10", 32'(ctrl), 32'(m_pipe[UW-1:16]));
      chk("R9", 32'(stk_err), 32'(e_err));
      if (m_pipe[3:0] == 4'd4 && tag == "R7") begin
        map_addr = map_addr ^ 8'h05;
        #1;
        e_addr = int'(map_addr);
        chk("R13", 32'(uaddr), 32'(e_addr));
      end
      @(posedge clk);
      model_clock(e_addr, e_act);
      @(negedge clk);
    end
  endtask

  localparam int ALW = 0, NEVER = 8, IFC = 4, IFZ = 5, IFV = 7, NOTC = 12, NOTN = 14, NOTV = 15;

  initial begin
    for (int a = 0; a < 256; a++) rom[a] = w(0, 0, 0, (a * 37) & 255);
    rom[1]   = w(2, ALW, 16, 8'h21);
    rom[16]  = w(2, ALW, 32, 8'h22);
    rom[32]  = w(2, ALW, 48, 8'h23);
    rom[48]  = w(2, ALW, 64, 8'h24);
    rom[64]  = w(2, ALW, 80, 8'h25);
    rom[80]  = w(3, ALW, 0, 8'h26);
    rom[65]  = w(3, ALW, 0, 8'h27);
    rom[33]  = w(3, ALW, 0, 8'h28);
    rom[17]  = w(3, ALW, 0, 8'h29);
    rom[3]   = w(3, IFZ, 0, 8'h30);
    rom[4]   = w(1, IFC, 8, 8'h31);
    rom[5]   = w(1, NOTN, 8, 8'h32);
    rom[6]   = w(2, IFV, 100, 8'h33);
    rom[7]   = w(9, ALW, 200, 8'h34);
    rom[8]   = w(4, ALW, 0, 8'h35);
    rom[100] = w(3, ALW, 0, 8'h36);
    rom[121] = w(2, NEVER, 0, 8'h37);
    rom[122] = w(5, ALW, 0, 8'h38);
    rom[140] = w(1, NOTC, 120, 8'h39);
    rom[141] = w(5, IFZ, 0, 8'h3A);
    rom[142] = w(1, ALW, 0, 8'h3B);
    rom[161] = w(3, NOTV, 0, 8'h3C);
    rom[162] = w(1, ALW, 0, 8'h3D);

    alu_flags = '0; map_addr = '0; irq_addr = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    chk("R1", 32'(uaddr), 0);
    chk("R1", 32'(ctrl), 0);
    chk("R1", 32'(stk_err), 0);
    model_reset();
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run(3000);

    // reset in the middle of a cycle acts at once
    #2 rst_n = 1'b0;
    #1;
    chk("R1", 32'(uaddr), 0);
    chk("R1", 32'(ctrl), 0);
    model_reset();
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run(400);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule